// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and the calendar in packed BCD bytes: seconds, minutes, hours, date, month, two-digit year, century and day of week. A one-cycle pulse on `tick_i`, normally one per second, advances the seconds. Carries then ripple through the fields in the same clock edge, so each register settles once per tick.

Software reaches the fields through a byte-wide register port. It has a write port with its own address, a combinational read port with a separate address, and a status byte. The status byte reports a battery indication taken from a pin and holds three general flag bits.

The hour byte carries its own format bit. With that bit set the hour counts 00 to 23. With it clear the hour counts 1 to 12 and a flag inside the hour byte marks the afternoon. The leap rule looks only at whether the two-digit year is divisible by four. The century byte moves from 19 to 20 when the year wraps.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read: seconds 00, minutes 00, hour 0x12 (12-hour mode, AM, i.e. midnight), date 01, month 01, year 00, day of week 0, century 0x20, status 0x00 except that bit 7 follows the battery pin.
- R2: On each clock edge where `tick_i` is 1, seconds advance in BCD from 00 to 59 and wrap to 00. The wrap advances minutes, which count the same way. Every carry in the chain takes effect in that same edge.
- R3: When hour bit 7 is 1 (24-hour mode), bits 5:0 count BCD 00 to 23. The step from 23 to 00 keeps bit 7 set and advances the date.
- R4: When hour bit 7 is 0 (12-hour mode), bits 4:0 hold BCD 1 to 12 and bit 5 is the afternoon flag (1 = PM). Going from 11 to 12 inverts the flag. Going from 12 to 01 leaves it alone. The date advances only on the step from 11 PM to 12 AM.
- R5: Day of week (offset 0x36, bits 2:0) steps 0 through 6 and back to 0 each time the date advances. A write whose bits 2:0 equal 7 is ignored.
- R6: Months 04, 06, 09 and 11 last 30 days, February lasts 28 or 29, and all other months last 31. A date at or past the month's last day steps to 01 and advances the month. Month 12 steps to 01 and advances the year.
- R7: February has 29 days whenever the BCD year is divisible by four, including year 00, and 28 otherwise.
- R8: The year steps 99 to 00. That wrap changes the century from 0x19 to 0x20, and a century of 0x20 stays 0x20. Century writes other than 0x19 or 0x20 are ignored.
- R9: The status byte (offset 0x3F) reads the battery pin in bit 7 and zero in bits 6:3. Bits 2:0 read back the last written value. Writes to bit 7 have no effect.
- R10: The map is seconds 0x30, minutes 0x31, hours 0x32, date 0x33, month 0x34, year 0x35, day of week 0x36, century 0x37 and status 0x3F. Write masks are: bit 7 dropped for seconds and minutes, bit 6 for hours, bits 7:6 for date and bits 7:5 for month. Any other address reads 0x00 and ignores writes.
- R11: A write to a field in a cycle with `tick_i` high loads the write data into that field. The other fields advance as the tick dictates, using the values held before that edge.
- R12: With `tick_i` low and no write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle advance pulse for the seconds |
| batt_i | input | 1 | Battery supply indication, shown in status bit 7 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Combinational read data |

## Verification
A register write and a tick can arrive in the same cycle. The write must win on its own field, while the other fields still follow the carry computed from their old values. The bench provokes this directly with a write of seconds during a tick at 59. It also mixes random writes into random ticks, often with seconds and minutes preloaded to 59 so that carries are in flight. After every edge each field is compared against a BCD-to-integer reference model that applies the tick first and the write second.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] bcd_byte_t;

  localparam logic [7:0] OFS_SEC  = 8'h30;
  localparam logic [7:0] OFS_MIN  = 8'h31;
  localparam logic [7:0] OFS_HOUR = 8'h32;
  localparam logic [7:0] OFS_DATE = 8'h33;
  localparam logic [7:0] OFS_MON  = 8'h34;
  localparam logic [7:0] OFS_YEAR = 8'h35;
  localparam logic [7:0] OFS_DOW  = 8'h36;
  localparam logic [7:0] OFS_CENT = 8'h37;
  localparam logic [7:0] OFS_STAT = 8'h3F;

  typedef enum logic [3:0] {
    SEL_SEC, SEL_MIN, SEL_HOUR, SEL_DATE, SEL_MON,
    SEL_YEAR, SEL_DOW, SEL_CENT, SEL_STAT, SEL_NONE
  } reg_sel_e;

  // add one to a two-digit packed BCD value (no wrap handling)
  function automatic bcd_byte_t bcd_inc(input bcd_byte_t v);
    bcd_byte_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input bcd_byte_t v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // last valid date of a month, in BCD; leap test is year mod 4 only
  function automatic bcd_byte_t month_last(input bcd_byte_t mon, input bcd_byte_t yr);
    logic [6:0] ybin;
    bcd_byte_t  r;
    ybin = bcd_to_bin(yr);
    case (mon)
      8'h02:                      r = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cal_bcd_wrap.sv
module cal_bcd_wrap
  import cal_pkg::*;
#(
  parameter bcd_byte_t MIN_VAL = 8'h00,
  parameter bcd_byte_t MAX_VAL = 8'h59
) (
  input  bcd_byte_t cur_i,
  input  logic      step_i,
  output bcd_byte_t nxt_o,
  output logic      wrap_o
);
  logic at_top;

  always_comb begin
    at_top = (cur_i >= MAX_VAL);
    wrap_o = step_i && at_top;
    if (!step_i)     nxt_o = cur_i;
    else if (at_top) nxt_o = MIN_VAL;
    else             nxt_o = bcd_inc(cur_i);
  end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
  import cal_pkg::*;
(
  input  bcd_byte_t cur_i,
  input  logic      step_i,
  output bcd_byte_t nxt_o,
  output logic      day_o
);
  logic      mode24;
  logic      pm;
  logic [4:0] h12;
  bcd_byte_t inc24;
  bcd_byte_t inc12;

  always_comb begin
    mode24 = cur_i[7];
    pm     = cur_i[5];
    h12    = cur_i[4:0];
    inc24  = bcd_inc({2'b00, cur_i[5:0]});
    inc12  = bcd_inc({3'b000, cur_i[4:0]});
    nxt_o  = cur_i;
    day_o  = 1'b0;
    if (step_i) begin
      if (mode24) begin
        if (cur_i[5:0] >= 6'h23) begin
          nxt_o = 8'h80;
          day_o = 1'b1;
        end else begin
          nxt_o = {2'b10, inc24[5:0]};
        end
      end else begin
        if (h12 == 5'h11) begin
          nxt_o = {2'b00, ~pm, 5'h12};
          day_o = pm;
        end else if (h12 >= 5'h12) begin
          nxt_o = {2'b00, pm, 5'h01};
        end else begin
          nxt_o = {2'b00, pm, inc12[4:0]};
        end
      end
    end
  end
endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
  import cal_pkg::*;
(
  input  bcd_byte_t date_i,
  input  bcd_byte_t mon_i,
  input  bcd_byte_t yr_i,
  input  logic      step_i,
  output bcd_byte_t date_o,
  output bcd_byte_t mon_o,
  output logic      year_step_o
);
  bcd_byte_t last_day;

  always_comb begin
    last_day    = month_last(mon_i, yr_i);
    date_o      = date_i;
    mon_o       = mon_i;
    year_step_o = 1'b0;
    if (step_i) begin
      if (date_i >= last_day) begin
        date_o = 8'h01;
        if (mon_i >= 8'h12) begin
          mon_o       = 8'h01;
          year_step_o = 1'b1;
        end else begin
          mon_o = bcd_inc(mon_i);
        end
      end else begin
        date_o = bcd_inc(date_i);
      end
    end
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              batt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam bcd_byte_t RST_HOUR = 8'h12;
  localparam bcd_byte_t CENT_LO  = 8'h19;
  localparam bcd_byte_t CENT_HI  = 8'h20;
  localparam int        DOW_W    = 3;
  localparam int        STAT_W   = 3;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a == ADDR_W'(OFS_SEC))  s = SEL_SEC;
    if (a == ADDR_W'(OFS_MIN))  s = SEL_MIN;
    if (a == ADDR_W'(OFS_HOUR)) s = SEL_HOUR;
    if (a == ADDR_W'(OFS_DATE)) s = SEL_DATE;
    if (a == ADDR_W'(OFS_MON))  s = SEL_MON;
    if (a == ADDR_W'(OFS_YEAR)) s = SEL_YEAR;
    if (a == ADDR_W'(OFS_DOW))  s = SEL_DOW;
    if (a == ADDR_W'(OFS_CENT)) s = SEL_CENT;
    if (a == ADDR_W'(OFS_STAT)) s = SEL_STAT;
    return s;
  endfunction

  logic rst_sync_n;

  cal_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // state
  bcd_byte_t         sec_q, min_q, hr_q, date_q, mon_q, yr_q;
  logic [DOW_W-1:0]  dow_q;
  logic              cen20_q;
  logic [STAT_W-1:0] stat_q;

  // next state
  bcd_byte_t         sec_d, min_d, hr_d, date_d, mon_d, yr_d;
  logic [DOW_W-1:0]  dow_d;
  logic              cen20_d;
  logic [STAT_W-1:0] stat_d;

  // carry chain
  bcd_byte_t sec_nx, min_nx, hr_nx, date_nx, mon_nx, yr_nx;
  logic      sec_wrap, min_wrap, day_carry, year_step, yr_wrap;
  logic [DOW_W-1:0] dow_nx;
  logic      cen20_nx;
  logic      upd_en;
  reg_sel_e  wr_sel, rd_sel;

  cal_bcd_wrap #(.MIN_VAL(8'h00), .MAX_VAL(8'h59)) u_sec (
    .cur_i (sec_q), .step_i (tick_i), .nxt_o (sec_nx), .wrap_o (sec_wrap)
  );

  cal_bcd_wrap #(.MIN_VAL(8'h00), .MAX_VAL(8'h59)) u_min (
    .cur_i (min_q), .step_i (sec_wrap), .nxt_o (min_nx), .wrap_o (min_wrap)
  );

  cal_hour_step u_hour (
    .cur_i (hr_q), .step_i (min_wrap), .nxt_o (hr_nx), .day_o (day_carry)
  );

  cal_date_step u_date (
    .date_i      (date_q),
    .mon_i       (mon_q),
    .yr_i        (yr_q),
    .step_i      (day_carry),
    .date_o      (date_nx),
    .mon_o       (mon_nx),
    .year_step_o (year_step)
  );

  cal_bcd_wrap #(.MIN_VAL(8'h00), .MAX_VAL(8'h99)) u_year (
    .cur_i (yr_q), .step_i (year_step), .nxt_o (yr_nx), .wrap_o (yr_wrap)
  );

  always_comb begin
    if (day_carry) dow_nx = (dow_q >= DOW_W'(6)) ? '0 : dow_q + DOW_W'(1);
    else           dow_nx = dow_q;
    cen20_nx = cen20_q | yr_wrap;
  end

  // write overrides the advanced value of the addressed field only
  always_comb begin
    wr_sel  = wr_en_i ? decode(wr_addr_i) : SEL_NONE;
    upd_en  = tick_i | wr_en_i;
    sec_d   = sec_nx;
    min_d   = min_nx;
    hr_d    = hr_nx;
    date_d  = date_nx;
    mon_d   = mon_nx;
    yr_d    = yr_nx;
    dow_d   = dow_nx;
    cen20_d = cen20_nx;
    stat_d  = stat_q;
    case (wr_sel)
      SEL_SEC:  sec_d  = wr_data_i & 8'h7F;
      SEL_MIN:  min_d  = wr_data_i & 8'h7F;
      SEL_HOUR: hr_d   = wr_data_i & 8'hBF;
      SEL_DATE: date_d = wr_data_i & 8'h3F;
      SEL_MON:  mon_d  = wr_data_i & 8'h1F;
      SEL_YEAR: yr_d   = wr_data_i;
      SEL_DOW:  if (wr_data_i[DOW_W-1:0] != '1) dow_d = wr_data_i[DOW_W-1:0];
      SEL_CENT: begin
        if (wr_data_i == CENT_LO) cen20_d = 1'b0;
        if (wr_data_i == CENT_HI) cen20_d = 1'b1;
      end
      SEL_STAT: stat_d = wr_data_i[STAT_W-1:0];
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sec_q   <= 8'h00;
      min_q   <= 8'h00;
      hr_q    <= RST_HOUR;
      date_q  <= 8'h01;
      mon_q   <= 8'h01;
      yr_q    <= 8'h00;
      dow_q   <= '0;
      cen20_q <= 1'b1;
      stat_q  <= '0;
    end else if (upd_en) begin
      sec_q   <= sec_d;
      min_q   <= min_d;
      hr_q    <= hr_d;
      date_q  <= date_d;
      mon_q   <= mon_d;
      yr_q    <= yr_d;
      dow_q   <= dow_d;
      cen20_q <= cen20_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    rd_sel = decode(rd_addr_i);
    case (rd_sel)
      SEL_SEC:  rd_data_o = sec_q;
      SEL_MIN:  rd_data_o = min_q;
      SEL_HOUR: rd_data_o = hr_q;
      SEL_DATE: rd_data_o = date_q;
      SEL_MON:  rd_data_o = mon_q;
      SEL_YEAR: rd_data_o = yr_q;
      SEL_DOW:  rd_data_o = {5'b00000, dow_q};
      SEL_CENT: rd_data_o = cen20_q ? CENT_HI : CENT_LO;
      SEL_STAT: rd_data_o = {batt_i, 4'b0000, stat_q};
      default:  rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import cal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              batt_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic [7:0]        sec_q,
  input logic [7:0]        min_q,
  input logic [7:0]        hr_q,
  input logic [7:0]        date_q,
  input logic [7:0]        mon_q,
  input logic [7:0]        yr_q,
  input logic [2:0]        dow_q,
  input logic              cen20_q
);
  AST_SEC_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_en_i && sec_q == 8'h59 |=> sec_q == 8'h00); // R2

  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_en_i && !hr_q[7] && hr_q[4:0] == 5'h11 && min_q == 8'h59 && sec_q == 8'h59
    |=> hr_q[5] != $past(hr_q[5])); // R4

  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dow_q != 3'd7); // R5

  AST_CENT_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cen20_q) && !$past(wr_en_i) |-> $past(yr_q) == 8'h99 && yr_q == 8'h00); // R8

  AST_STAT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i == ADDR_W'(OFS_STAT) |-> rd_data_o[7] == batt_i && rd_data_o[6:3] == 4'h0); // R9

  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_addr_i == ADDR_W'(OFS_SEC) |=> sec_q == ($past(wr_data_i) & 8'h7F)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !wr_en_i |=> $stable(sec_q) && $stable(min_q) && $stable(hr_q)
      && $stable(date_q) && $stable(mon_q) && $stable(yr_q)); // R12
endmodule

bind bcd_calendar_core bcd_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick_i    (tick_i),
  .batt_i    (batt_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .sec_q     (sec_q),
  .min_q     (min_q),
  .hr_q      (hr_q),
  .date_q    (date_q),
  .mon_q     (mon_q),
  .yr_q      (yr_q),
  .dow_q     (dow_q),
  .cen20_q   (cen20_q)
);

// File: tb/sim_bcd_calendar_core.sv
module sim_bcd_calendar_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       batt = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  bcd_calendar_core u0 (
    .clk (clk), .rst_n (rst_n), .tick_i (tick), .batt_i (batt),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data)
  );

  // reference model state
  logic [7:0] m_sec, m_min, m_hr, m_date, m_mon, m_yr;
  int         m_dow, m_cen;
  logic [2:0] m_st;

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic model_reset();
    m_sec = 8'h00; m_min = 8'h00; m_hr = 8'h12; m_date = 8'h01;
    m_mon = 8'h01; m_yr = 8'h00; m_dow = 0; m_cen = 20; m_st = 3'b000;
  endtask

  task automatic model_tick();
    int v, h, dim;
    bit c, pm;
    logic [7:0] t;
    v = b2i(m_sec);
    if (v >= 59) begin m_sec = 8'h00; c = 1; end else begin m_sec = i2b(v + 1); c = 0; end
    if (c) begin
      v = b2i(m_min);
      if (v >= 59) begin m_min = 8'h00; c = 1; end else begin m_min = i2b(v + 1); c = 0; end
    end
    if (c) begin
      if (m_hr[7]) begin
        h = b2i({2'b00, m_hr[5:0]});
        if (h >= 23) begin m_hr = 8'h80; c = 1; end
        else begin m_hr = 8'h80 | i2b(h + 1); c = 0; end
      end else begin
        h = b2i({3'b000, m_hr[4:0]});
        pm = m_hr[5];
        c = 0;
        if (h == 11) begin h = 12; c = pm; pm = !pm; end
        else if (h >= 12) h = 1;
        else h = h + 1;
        t = i2b(h);
        m_hr = {2'b00, pm, t[4:0]};
      end
    end
    if (c) begin
      m_dow = (m_dow == 6) ? 0 : m_dow + 1;
      v = b2i(m_mon);
      if (v == 2) dim = (b2i(m_yr) % 4 == 0) ? 29 : 28;
      else if (v == 4 || v == 6 || v == 9 || v == 11) dim = 30;
      else dim = 31;
      if (b2i(m_date) >= dim) begin
        m_date = 8'h01;
        if (v >= 12) begin
          m_mon = 8'h01;
          if (b2i(m_yr) >= 99) begin m_yr = 8'h00; m_cen = 20; end
          else m_yr = i2b(b2i(m_yr) + 1);
        end else m_mon = i2b(v + 1);
      end else m_date = i2b(b2i(m_date) + 1);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h30: m_sec  = d & 8'h7F;
      8'h31: m_min  = d & 8'h7F;
      8'h32: m_hr   = d & 8'hBF;
      8'h33: m_date = d & 8'h3F;
      8'h34: m_mon  = d & 8'h1F;
      8'h35: m_yr   = d;
      8'h36: if (d[2:0] != 3'd7) m_dow = int'(d[2:0]);
      8'h37: begin if (d == 8'h19) m_cen = 19; if (d == 8'h20) m_cen = 20; end
      8'h3F: m_st = d[2:0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h30: return m_sec;
      8'h31: return m_min;
      8'h32: return m_hr;
      8'h33: return m_date;
      8'h34: return m_mon;
      8'h35: return m_yr;
      8'h36: return 8'(m_dow);
      8'h37: return (m_cen == 20) ? 8'h20 : 8'h19;
      8'h3F: return {batt, 4'b0000, m_st};
      default: return 8'h00;
    endcase
  endfunction

  // one clock: drive at falling edge, tick first then write in the model
  task automatic step(input bit t, input bit w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
    if (t) model_tick();
    if (w) model_write(a, d);
    @(posedge clk);
    #2;
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [7:0] addrs [10] = '{8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h3F, 8'h38};
    for (int i = 0; i < 10; i++) begin
      rd_addr = addrs[i];
      #0.5;
      n_chk++;
      if (rd_data !== exp_rd(addrs[i])) begin
        n_bad++;
        $display("FAIL %s addr %h: actual %h expected %h", req, addrs[i], rd_data, exp_rd(addrs[i]));
      end
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(0, 1, a, d);
  endtask

  task automatic set_time(input logic [7:0] hr, input logic [7:0] mn, input logic [7:0] sc);
    wr(8'h32, hr); wr(8'h31, mn); wr(8'h30, sc);
  endtask

  task automatic set_day(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt);
    wr(8'h35, yr); wr(8'h34, mo); wr(8'h33, dt);
  endtask

  function automatic logic [7:0] rand_val(input logic [7:0] a);
    logic [7:0] t;
    case (a)
      8'h30, 8'h31: return ($urandom % 2) ? 8'h59 : i2b($urandom % 60);
      8'h32: begin
        if ($urandom % 2) begin t = i2b($urandom % 24); return {2'b10, t[5:0]}; end
        t = i2b(1 + $urandom % 12);
        return {2'b00, 1'($urandom % 2), t[4:0]};
      end
      8'h33: return i2b(1 + $urandom % 31);
      8'h34: return i2b(1 + $urandom % 12);
      8'h35: return ($urandom % 2) ? 8'h99 : i2b($urandom % 100);
      8'h36: return 8'($urandom % 8);
      8'h37: return ($urandom % 3 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h19 : 8'h20);
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R12: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] amap [10] = '{8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h3F, 8'h38};
    void'($urandom(32'h5EED_0C1A));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) step(0, 0, 8'h00, 8'h00);
    check_all("R1");

    // R12: idle cycles hold
    repeat (5) step(0, 0, 8'h00, 8'h00);
    check_all("R12");

    // R2: seconds and minutes carry
    set_time(8'h85, 8'h59, 8'h58); step(1, 0, 0, 0); check_all("R2");
    step(1, 0, 0, 0); check_all("R2");

    // R4: 11:59:59 PM -> 12:00:00 AM advances date; AM 11 -> PM 12; 12 -> 1
    set_day(8'h23, 8'h05, 8'h10);
    set_time(8'h31, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R4");
    set_time(8'h11, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R4");
    set_time(8'h32, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R4");

    // R3: 24-hour wrap
    set_time(8'hA3, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R3");

    // R6: 30-day month end
    set_day(8'h23, 8'h04, 8'h30); set_time(8'hA3, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R6");

    // R7: leap and non-leap February, year 00 is leap
    set_day(8'h04, 8'h02, 8'h28); set_time(8'hA3, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R7");
    set_time(8'hA3, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R7");
    set_day(8'h03, 8'h02, 8'h28); set_time(8'hA3, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R7");
    set_day(8'h00, 8'h02, 8'h28); set_time(8'hA3, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R7");

    // R8 and R5: new year with century roll, day of week 6 -> 0, bad writes ignored
    wr(8'h37, 8'h19); wr(8'h36, 8'h06);
    set_day(8'h99, 8'h12, 8'h31); set_time(8'hA3, 8'h59, 8'h59); step(1, 0, 0, 0); check_all("R8");
    wr(8'h37, 8'h45); check_all("R8");
    wr(8'h36, 8'h07); check_all("R5");

    // R11: write during tick on the seconds field
    set_time(8'h85, 8'h20, 8'h59); step(1, 1, 8'h30, 8'h10); check_all("R11");

    // R9: status bits and battery pin
    wr(8'h3F, 8'hFF); check_all("R9");
    batt = 1'b1; step(0, 0, 0, 0); check_all("R9");

    // R10: unmapped address ignores writes, masks on writes
    wr(8'h38, 8'hFF); wr(8'h33, 8'hD5); wr(8'h34, 8'hE9); check_all("R10");

    // random mix of ticks and writes
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = amap[$urandom % 10];
      batt = 1'($urandom % 2);
      if ($urandom % 4 == 0) step(1'($urandom % 3 != 0), 1, a, rand_val(a));
      else                   step(1'($urandom % 3 != 0), 0, 8'h00, 8'h00);
      check_all("R11");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule